// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block holds the interrupt and run-control state of a multi-channel audio DMA engine. Channels come in pairs: the even member of each pair always moves data from memory to a device (transmit), the odd member always moves data from a device to memory (receive). The descriptor engine is outside this block. It reports each finished descriptor and each fault as a one-cycle pulse on a per-channel input, and the block records these pulses as cause bits.

Every channel keeps a separate copy of its cause bits and interrupt mask for each interrupt output line. Software clears a cause bit in one line's copy by writing a 1 to it. For each line the block forms a transmit summary and a receive summary, each with one bit per channel pair. It raises that line while any of those bits is set, so a handler reads two words to find the channels that want service. Two start and two stop registers, one of each per direction and indexed by pair, set and clear the per-channel run enables that go to the engine.

The register port is a plain single-cycle interface. A write takes effect at the clock edge where `reg_we` is high. A read is combinational from `reg_addr`. There is no stream data path and therefore no back-pressure.

Top module: `dma_irq_aggregator`

## Requirements
- R1: A write to TX_START (address 0x00) with bit p set turns on run_en[2p]. A write to RX_START (0x02) with bit p set turns on run_en[2p+1]. Enables already on stay on.
- R2: A write to TX_STOP (0x01) or RX_STOP (0x03) with bit p set turns off the enable of the channel of that direction in pair p. Zero bits, and bits for channels that are not running, change nothing.
- R3: A pulse on done_evt[c] sets bit 0 of the cause word of channel c in every line. A pulse on err_evt[c] sets bit 6 in every line. The cause word of channel c, line k is read at 0x40 + 8c + k. All other bits read 0.
- R4: Writing a 1 to bit 0 or bit 6 of a cause word clears that bit in the addressed line only. Zero bits leave the word unchanged, and the other lines of the same channel are not affected.
- R5: If an event pulse and a clearing write to the same bit fall in the same cycle, the bit stays set.
- R6: The mask word of channel c, line k is at 0x44 + 8c + k. It stores only bit 0 and bit 6 and reads back 0 in every other bit.
- R7: Bit p of the transmit summary of line k (address 0x10 + k) is set when channel 2p has some cause bit set with the same mask bit set in line k. Bit p of the receive summary (0x18 + k) does the same for channel 2p+1.
- R8: irq_o[k] is high exactly when the transmit or the receive summary of line k is nonzero. When both summaries are zero the line is low.
- R9: After reset all run enables, cause bits and mask bits are 0 and every irq_o line is low.
- R10: An address that has no register reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| done_evt | input | NCH | Per-channel descriptor-finished pulse |
| err_evt | input | NCH | Per-channel fault pulse |
| irq_o | output | NLINES | Interrupt output lines |
| run_en | output | NCH | Per-channel run enable |

## Verification
The bench targets the mapping from pair index to channel. A design that ignored channel parity would enable, or report in a summary, the wrong member of a pair. It checks that a clear written to one line leaves the other lines of the same channel set; a design that shared the cause bits between lines would clear all of them. It drives an event and a clearing write in the same cycle, which a design with the wrong priority would lose. It also checks that a masked cause keeps its line low and that a stop for a channel that is not running changes nothing.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int DATA_W      = 32;
  localparam int TX_START_A  = 'h00;
  localparam int TX_STOP_A   = 'h01;
  localparam int RX_START_A  = 'h02;
  localparam int RX_STOP_A   = 'h03;
  localparam int TX_SUM_BASE = 'h10;
  localparam int RX_SUM_BASE = 'h18;
  localparam int CHAN_BASE   = 'h40;
  localparam int CHAN_STRIDE = 8;
  localparam int MASK_OFS    = 4;
  localparam int DONE_BIT    = 0;
  localparam int ERR_BIT     = 6;

  // two stored cause/mask bits: [1]=error, [0]=descriptor done
  typedef logic [1:0] evbits_t;

  function automatic int cause_addr(int ch, int line);
    return CHAN_BASE + ch * CHAN_STRIDE + line;
  endfunction

  function automatic int mask_addr(int ch, int line);
    return CHAN_BASE + ch * CHAN_STRIDE + MASK_OFS + line;
  endfunction

  function automatic logic [DATA_W-1:0] pack_word(evbits_t b);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DONE_BIT] = b[0];
    w[ERR_BIT]  = b[1];
    return w;
  endfunction

  function automatic evbits_t unpack_word(logic [DATA_W-1:0] w);
    return {w[ERR_BIT], w[DONE_BIT]};
  endfunction

endpackage

// File: rtl/irqagg_cause_bank.sv
module irqagg_cause_bank
  import irqagg_pkg::*;
#(
  parameter int NLINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_evt,
  input  logic                 err_evt,
  input  logic [NLINES-1:0]    clr_we,
  input  logic [NLINES-1:0]    mask_we,
  input  evbits_t              wbits,
  output evbits_t [NLINES-1:0] cause_o,
  output evbits_t [NLINES-1:0] mask_o,
  output logic    [NLINES-1:0] hit_o
);

  evbits_t setbits;
  assign setbits = {err_evt, done_evt};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    evbits_t cause_q, mask_q, clrbits;

    assign clrbits = clr_we[l] ? wbits : 2'b00;

    // the event OR is applied after the clear, so an event in the same cycle wins
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cause_q <= '0;
        mask_q  <= '0;
      end else begin
        cause_q <= (cause_q & ~clrbits) | setbits;
        if (mask_we[l]) mask_q <= wbits;
      end
    end

    assign cause_o[l] = cause_q;
    assign mask_o[l]  = mask_q;
    assign hit_o[l]   = |(cause_q & mask_q);
  end

endmodule

// File: rtl/irqagg_run_ctl.sv
module irqagg_run_ctl #(
  parameter int NCH = 8,
  localparam int NPAIR = NCH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start,
  input  logic             tx_stop,
  input  logic             rx_start,
  input  logic             rx_stop,
  input  logic [NPAIR-1:0] pair_bits,
  output logic [NCH-1:0]   run_en
);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic tx_q, rx_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tx_q <= 1'b0;
        rx_q <= 1'b0;
      end else begin
        if (tx_start && pair_bits[p]) tx_q <= 1'b1;
        else if (tx_stop && pair_bits[p]) tx_q <= 1'b0;
        if (rx_start && pair_bits[p]) rx_q <= 1'b1;
        else if (rx_stop && pair_bits[p]) rx_q <= 1'b0;
      end
    end

    // the even channel of a pair is transmit, the odd channel is receive
    assign run_en[2*p]   = tx_q;
    assign run_en[2*p+1] = rx_q;
  end

endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary #(
  parameter int NCH    = 8,
  parameter int NLINES = 4,
  localparam int NPAIR = NCH / 2
) (
  input  logic [NCH-1:0][NLINES-1:0]   hit,
  output logic [NLINES-1:0][NPAIR-1:0] tx_sum,
  output logic [NLINES-1:0][NPAIR-1:0] rx_sum,
  output logic [NLINES-1:0]            irq
);

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      assign tx_sum[l][p] = hit[2*p][l];
      assign rx_sum[l][p] = hit[2*p+1][l];
    end
    assign irq[l] = (|tx_sum[l]) | (|rx_sum[l]);
  end

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int NLINES = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    done_evt,
  input  logic [NCH-1:0]    err_evt,
  output logic [NLINES-1:0] irq_o,
  output logic [NCH-1:0]    run_en
);

  localparam int NPAIR = NCH / 2;

  evbits_t wbits;
  assign wbits = unpack_word(reg_wdata);

  logic [NCH-1:0][NLINES-1:0]   clr_we, mask_we, hit;
  evbits_t [NCH-1:0][NLINES-1:0] cause_q, mask_q;
  logic [NLINES-1:0][NPAIR-1:0] tx_sum, rx_sum;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    for (genvar l = 0; l < NLINES; l++) begin : g_dec
      assign clr_we[c][l]  = reg_we && (reg_addr == ADDR_W'(cause_addr(c, l)));
      assign mask_we[c][l] = reg_we && (reg_addr == ADDR_W'(mask_addr(c, l)));
    end

    irqagg_cause_bank #(.NLINES(NLINES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_evt (done_evt[c]),
      .err_evt  (err_evt[c]),
      .clr_we   (clr_we[c]),
      .mask_we  (mask_we[c]),
      .wbits    (wbits),
      .cause_o  (cause_q[c]),
      .mask_o   (mask_q[c]),
      .hit_o    (hit[c])
    );
  end

  irqagg_run_ctl #(.NCH(NCH)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (reg_we && reg_addr == ADDR_W'(TX_START_A)),
    .tx_stop   (reg_we && reg_addr == ADDR_W'(TX_STOP_A)),
    .rx_start  (reg_we && reg_addr == ADDR_W'(RX_START_A)),
    .rx_stop   (reg_we && reg_addr == ADDR_W'(RX_STOP_A)),
    .pair_bits (reg_wdata[NPAIR-1:0]),
    .run_en    (run_en)
  );

  irqagg_summary #(.NCH(NCH), .NLINES(NLINES)) u_sum (
    .hit    (hit),
    .tx_sum (tx_sum),
    .rx_sum (rx_sum),
    .irq    (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    for (int l = 0; l < NLINES; l++) begin
      if (reg_addr == ADDR_W'(TX_SUM_BASE + l)) reg_rdata = 32'(tx_sum[l]);
      if (reg_addr == ADDR_W'(RX_SUM_BASE + l)) reg_rdata = 32'(rx_sum[l]);
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == ADDR_W'(cause_addr(c, l))) reg_rdata = pack_word(cause_q[c][l]);
        if (reg_addr == ADDR_W'(mask_addr(c, l)))  reg_rdata = pack_word(mask_q[c][l]);
      end
    end
  end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int NLINES = 4,
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_we,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [31:0]                   reg_wdata,
  input logic [NCH-1:0]                done_evt,
  input logic [NLINES-1:0]             irq_o,
  input logic [NCH-1:0]                run_en,
  input evbits_t [NCH-1:0][NLINES-1:0] cause_q,
  input logic [NLINES-1:0][NCH/2-1:0]  tx_sum,
  input logic [NLINES-1:0][NCH/2-1:0]  rx_sum
);

  for (genvar p = 0; p < NCH / 2; p++) begin : g_pair
    // R1
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(TX_START_A) && reg_wdata[p]) |=> run_en[2*p]);
    // R2
    rx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(RX_STOP_A) && reg_wdata[p]) |=> !run_en[2*p+1]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    for (genvar l = 0; l < NLINES; l++) begin : g_line
      // R5
      done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt[c] |=> cause_q[c][l][0]);
      // R4
      done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(cause_addr(c, l)) && reg_wdata[DONE_BIT] && !done_evt[c])
        |=> !cause_q[c][l][0]);
    end
  end

  for (genvar l = 0; l < NLINES; l++) begin : g_irq
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sum[l] == '0 && rx_sum[l] == '0) |-> !irq_o[l]);
  end

endmodule

bind dma_irq_aggregator irqagg_checker #(.NCH(NCH), .NLINES(NLINES), .ADDR_W(ADDR_W)) u_irqagg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .done_evt  (done_evt),
  .irq_o     (irq_o),
  .run_en    (run_en),
  .cause_q   (cause_q),
  .tx_sum    (tx_sum),
  .rx_sum    (rx_sum)
);

// File: tb/dma_irq_aggregator_bench.sv
`timescale 1ns/1ps
module dma_irq_aggregator_bench;

  localparam int NCH = 8, NLINES = 4, ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NCH-1:0]    done_evt = '0;
  logic [NCH-1:0]    err_evt = '0;
  logic [NLINES-1:0] irq_o;
  logic [NCH-1:0]    run_en;

  always #10 clk = ~clk;

  dma_irq_aggregator #(.NCH(NCH), .NLINES(NLINES), .ADDR_W(ADDR_W)) u_dma_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_evt(done_evt),
    .err_evt(err_evt), .irq_o(irq_o), .run_en(run_en)
  );

  // sel: 0 = read data, 1 = irq lines, 2 = run enables
  typedef struct {
    int          sel;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic chk_v = 1'b0;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  // monitor: samples mid-low-phase, well away from the active edge
  always begin
    @(negedge clk);
    #5;
    if (chk_v && q.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = q.pop_front();
      case (e.sel)
        0:       act = reg_rdata;
        1:       act = 32'(irq_o);
        default: act = 32'(run_en);
      endcase
      n_chk++;
      if (act !== e.val) begin
        n_fail++;
        $display("FAIL %s: got 0x%0h expected 0x%0h", e.tag, act, e.val);
      end
    end
  end

  task automatic expect_item(int sel, logic [ADDR_W-1:0] a, logic [31:0] v, string tag);
    exp_t e;
    @(negedge clk);
    reg_addr = a;
    e.sel = sel; e.val = v; e.tag = tag;
    q.push_back(e);
    chk_v = 1'b1;
    @(negedge clk);
    chk_v = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] v, string tag);
    expect_item(0, a, v, tag);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(bit is_err, int ch);
    @(negedge clk);
    if (is_err) err_evt[ch] = 1'b1; else done_evt[ch] = 1'b1;
    @(negedge clk);
    err_evt = '0; done_evt = '0;
  endtask

  function automatic logic [ADDR_W-1:0] ca(int c, int l); return ADDR_W'('h40 + 8*c + l); endfunction
  function automatic logic [ADDR_W-1:0] ma(int c, int l); return ADDR_W'('h44 + 8*c + l); endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    expect_item(2, 0, 0, "R9 run_en after reset");
    expect_item(1, 0, 0, "R9 irq after reset");
    rd(ca(0, 0), 0, "R9 cause after reset");
    rd(ma(0, 0), 0, "R9 mask after reset");
    // R1 parity mapping of start registers
    wr('h00, 32'h5);
    expect_item(2, 0, 32'h11, "R1 tx start pairs 0,2");
    wr('h02, 32'h2);
    expect_item(2, 0, 32'h19, "R1 rx start pair 1");
    // R2 stop
    wr('h01, 32'h1);
    expect_item(2, 0, 32'h18, "R2 tx stop pair 0");
    wr('h03, 32'h0);
    wr('h01, 32'h2);
    expect_item(2, 0, 32'h18, "R2 zero bits and idle channel unchanged");
    // R3 event sets cause in every line
    pulse(0, 3);
    rd(ca(3, 0), 32'h1, "R3 done ch3 line0");
    rd(ca(3, 3), 32'h1, "R3 done ch3 line3");
    expect_item(1, 0, 0, "R8 masked cause keeps irq low");
    rd('h18, 0, "R7 rx summary masked");
    // R6 mask storage, R7/R8 summary
    wr(ma(3, 1), 32'hFFFF_FFFF);
    rd(ma(3, 1), 32'h41, "R6 mask readback bits 0 and 6");
    expect_item(1, 0, 32'h2, "R8 irq line1");
    rd('h19, 32'h2, "R7 rx summary line1 pair1");
    rd('h11, 0, "R7 tx summary line1 empty");
    pulse(1, 2);
    rd(ca(2, 2), 32'h40, "R3 err ch2 line2");
    wr(ma(2, 2), 32'h40);
    rd('h12, 32'h2, "R7 tx summary line2 pair1");
    expect_item(1, 0, 32'h6, "R8 irq lines 1,2");
    // R4 clear per line
    wr(ca(3, 1), 32'h1);
    rd(ca(3, 1), 0, "R4 cleared line1");
    rd(ca(3, 0), 32'h1, "R4 other line untouched");
    expect_item(1, 0, 32'h4, "R8 irq after clear");
    wr(ca(2, 2), 32'h0);
    rd(ca(2, 2), 32'h40, "R4 zero write no effect");
    // R5 event beats clear in the same cycle
    @(negedge clk);
    err_evt[2] = 1'b1; reg_we = 1'b1; reg_addr = ca(2, 2); reg_wdata = 32'h40;
    @(negedge clk);
    err_evt = '0; reg_we = 1'b0;
    rd(ca(2, 2), 32'h40, "R5 event wins over clear");
    wr(ca(2, 2), 32'h40);
    rd(ca(2, 2), 0, "R4 clear err bit");
    expect_item(1, 0, 0, "R8 all lines quiet");
    // R7 highest pair and transmit pair 0
    pulse(0, 7);
    wr(ma(7, 3), 32'h1);
    rd('h1B, 32'h8, "R7 rx summary line3 pair3");
    pulse(0, 0);
    wr(ma(0, 0), 32'h1);
    rd('h10, 32'h1, "R7 tx summary line0 pair0");
    expect_item(1, 0, 32'h9, "R8 irq lines 0,3");
    // R10 hole in the map
    rd('h3F, 0, "R10 unmapped address");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule